// File: doc/BRIEF.md
# Universal Shift Register

This block is a clocked register whose action on each rising edge is picked by a two-bit mode code: take a whole word from the parallel inputs, move every bit one place toward the low end, move every bit one place toward the high end, or keep its contents. Every flip-flop sits behind its own four-way selector. An active-low clear, sampled on the clock edge, empties the register and overrides the mode.

The register is built from 4-bit slices. A parameter sets how many slices are chained. The chaining passes bits across slice boundaries in both shift directions, so two slices act as one 8-bit register. In that form a word loaded in parallel can be sent out one bit per clock from bit 0. A stream fed into the low-end serial input comes back as a parallel word after eight shifts.

Bit 0 is the least significant bit. The low-end serial input fills bit 0. The high-end serial input fills the top bit.

Top module: `usr_top`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `data_out` becomes all zeros after that edge, whatever the mode and the other inputs are.
- R2: Mode 2'b11 copies `data_in` into the register at the rising edge, and both serial inputs are ignored.
- R3: Mode 2'b10 moves bits toward the low end. The top bit takes `fill_hi`, and each bit i below the top takes the old bit i+1.
- R4: Mode 2'b01 moves bits toward the high end. Bit 0 takes `fill_lo`, and each bit i above 0 takes the old bit i-1.
- R5: Mode 2'b00 keeps `data_out` unchanged, whatever values `data_in`, `fill_hi` and `fill_lo` carry.
- R6: With two slices (the default, 8 bits), bit 3 passes into bit 4 in mode 2'b01, and bit 4 passes into bit 3 in mode 2'b10. The chained slices therefore behave as one 8-bit register, and this supports parallel-to-serial and serial-to-parallel conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous active-low clear; it has priority over the mode |
| mode | input | 2 | 00 hold, 01 move toward high end, 10 move toward low end, 11 parallel load |
| fill_hi | input | 1 | Serial bit that enters the top bit in mode 10 |
| fill_lo | input | 1 | Serial bit that enters bit 0 in mode 01 |
| data_in | input | SLICES*SLICE_W | Parallel load word |
| data_out | output | SLICES*SLICE_W | Register contents |

## Verification
The shifts start from asymmetric words such as 0xA5 and 0x3C. With these words, a bit that lands in the wrong place, or a serial input that enters at the wrong end, gives a visibly different result. Opposite serial values are applied in the two directions, so the two serial inputs cannot be swapped without notice. Patterns whose set bits sit on the slice boundary (0x3C, 0x81) show whether the chain carries a bit across slices in each direction. Hold and load are applied with all-ones on the inputs they must ignore, and a full eight-step serial send and receive confirms that the bit order comes out right end to end.

// File: rtl/usr_pkg.sv
// Package usr_pkg
// Holds the shared mode encoding of the universal shift register.
// Assumes a two-bit mode bus driven by the user of the block.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,   // toward high index, fill_lo enters bit 0
        MODE_SHL  = 2'b10,   // toward low index, fill_hi enters top bit
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_bit_mux.sv
// Module usr_bit_mux
// Picks the next value of one register bit from the mode and clear.
// Assumes the neighbour bits, or the serial fills at the ends, are supplied
// by the enclosing slice. Clear wins over every mode.
module usr_bit_mux
    import usr_pkg::*;
(
    input  logic      clear_n,
    input  usr_mode_e mode,
    input  logic      cur_bit,
    input  logic      load_bit,
    input  logic      from_above,
    input  logic      from_below,
    output logic      next_bit
);

    // Purpose: select next bit value with clear taking priority.
    always_comb begin
        if (!clear_n) begin
            next_bit = 1'b0;
        end else begin
            unique case (mode)
                MODE_LOAD: next_bit = load_bit;
                MODE_SHL:  next_bit = from_above;
                MODE_SHR:  next_bit = from_below;
                default:   next_bit = cur_bit;
            endcase
        end
    end

endmodule

// File: rtl/usr_slice.sv
// Module usr_slice
// One SLICE_W-bit section of the shift register: a selector per bit and
// the flip-flops. Assumes the end-bit neighbours arrive on fill_hi/fill_lo,
// either from the outside world or from an adjacent slice.
module usr_slice
    import usr_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               clear_n,
    input  usr_mode_e          mode,
    input  logic               fill_hi,
    input  logic               fill_lo,
    input  logic [SLICE_W-1:0] din,
    output logic [SLICE_W-1:0] q
);

    localparam int TOP = SLICE_W - 1;

    logic [SLICE_W-1:0] above;
    logic [SLICE_W-1:0] below;
    logic [SLICE_W-1:0] nxt;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        // Neighbour wiring: end bits take the serial fills.
        if (i == TOP) begin : g_top
            assign above[i] = fill_hi;
        end else begin : g_mid_a
            assign above[i] = q[i+1];
        end
        if (i == 0) begin : g_bot
            assign below[i] = fill_lo;
        end else begin : g_mid_b
            assign below[i] = q[i-1];
        end

        usr_bit_mux u_mux (
            .clear_n   (clear_n),
            .mode      (mode),
            .cur_bit   (q[i]),
            .load_bit  (din[i]),
            .from_above(above[i]),
            .from_below(below[i]),
            .next_bit  (nxt[i])
        );
    end

    // Purpose: capture the selected next state on the rising edge.
    always_ff @(posedge clk) begin
        q <= nxt;
    end

endmodule

// File: rtl/usr_top.sv
// Module usr_top
// Universal shift register built from SLICES chained slices of SLICE_W bits.
// Assumes all control is synchronous to clk. Slice k holds bits
// [k*SLICE_W +: SLICE_W]. Adjacent slices exchange their boundary bits so
// that a shift crosses slice borders in both directions.
module usr_top
    import usr_pkg::*;
#(
    parameter int SLICES  = 2,
    parameter int SLICE_W = 4
) (
    input  logic                        clk,
    input  logic                        clear_n,
    input  logic [1:0]                  mode,
    input  logic                        fill_hi,
    input  logic                        fill_lo,
    input  logic [SLICES*SLICE_W-1:0]   data_in,
    output logic [SLICES*SLICE_W-1:0]   data_out
);

    localparam int W = SLICES * SLICE_W;

    usr_mode_e         mode_e;
    logic [SLICES-1:0] link_hi;
    logic [SLICES-1:0] link_lo;

    // Purpose: map the raw mode bus onto the shared enum.
    always_comb begin
        mode_e = usr_mode_e'(mode);
    end

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        // Chain wiring: the top slice takes the external high fill, the
        // others take the lowest bit of the slice above them.
        if (k == SLICES - 1) begin : g_hi_ext
            assign link_hi[k] = fill_hi;
        end else begin : g_hi_chain
            assign link_hi[k] = data_out[(k+1)*SLICE_W];
        end
        // The bottom slice takes the external low fill, the others take
        // the top bit of the slice below them.
        if (k == 0) begin : g_lo_ext
            assign link_lo[k] = fill_lo;
        end else begin : g_lo_chain
            assign link_lo[k] = data_out[k*SLICE_W-1];
        end

        usr_slice #(.SLICE_W(SLICE_W)) u_slice (
            .clk    (clk),
            .clear_n(clear_n),
            .mode   (mode_e),
            .fill_hi(link_hi[k]),
            .fill_lo(link_lo[k]),
            .din    (data_in[k*SLICE_W +: SLICE_W]),
            .q      (data_out[k*SLICE_W +: SLICE_W])
        );
    end

endmodule

// File: rtl/usr_checker.sv
// Module usr_checker
// Temporal checks on the ports of usr_top. A one-bit flag marks the first
// edge, so that no $past value from before time zero is used.
module usr_checker #(
    parameter int SLICES  = 2,
    parameter int SLICE_W = 4
) (
    input logic                      clk,
    input logic                      clear_n,
    input logic [1:0]                mode,
    input logic                      fill_hi,
    input logic                      fill_lo,
    input logic [SLICES*SLICE_W-1:0] data_in,
    input logic [SLICES*SLICE_W-1:0] data_out
);

    localparam int W = SLICES * SLICE_W;

    logic seen = 1'b0;

    // Purpose: note that at least one edge has occurred.
    always_ff @(posedge clk) begin
        seen <= 1'b1;
    end

    assert_clear_zero_R1: assert property (@(posedge clk)
        seen && !$past(clear_n) |-> data_out == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!clear_n)
        seen && $past(clear_n) && $past(mode) == 2'b11
        |-> data_out == $past(data_in));

    assert_shl_R3: assert property (@(posedge clk) disable iff (!clear_n)
        seen && $past(clear_n) && $past(mode) == 2'b10
        |-> data_out == {$past(fill_hi), $past(data_out[W-1:1])});

    assert_shr_R4: assert property (@(posedge clk) disable iff (!clear_n)
        seen && $past(clear_n) && $past(mode) == 2'b01
        |-> data_out == {$past(data_out[W-2:0]), $past(fill_lo)});

    assert_hold_R5: assert property (@(posedge clk) disable iff (!clear_n)
        seen && $past(clear_n) && $past(mode) == 2'b00
        |-> $stable(data_out));

    if (SLICES > 1) begin : g_chain_chk
        assert_cross_up_R6: assert property (@(posedge clk) disable iff (!clear_n)
            seen && $past(clear_n) && $past(mode) == 2'b01
            |-> data_out[SLICE_W] == $past(data_out[SLICE_W-1]));

        assert_cross_down_R6: assert property (@(posedge clk) disable iff (!clear_n)
            seen && $past(clear_n) && $past(mode) == 2'b10
            |-> data_out[SLICE_W-1] == $past(data_out[SLICE_W]));
    end

endmodule

bind usr_top usr_checker #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_chk (
    .clk     (clk),
    .clear_n (clear_n),
    .mode    (mode),
    .fill_hi (fill_hi),
    .fill_lo (fill_lo),
    .data_in (data_in),
    .data_out(data_out)
);

// File: tb/usr_top_test.sv
// Bench for usr_top (default two slices, 8 bits): a table of vectors walked
// by one loop, then directed tests for clear priority and serial conversion.
module usr_top_test;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       fill_hi = 1'b0;
    logic       fill_lo = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    usr_top uut (
        .clk     (clk),
        .clear_n (clear_n),
        .mode    (mode),
        .fill_hi (fill_hi),
        .fill_lo (fill_lo),
        .data_in (data_in),
        .data_out(data_out)
    );

    // Vector layout: {clear_n, mode[1:0], fill_hi, fill_lo, data_in[7:0], expected[7:0]}
    localparam logic [20:0] VEC [14] = '{
        {1'b1, 2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R2 load
        {1'b1, 2'b00, 1'b1, 1'b1, 8'hFF, 8'hA5},  // R5 hold ignores inputs
        {1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 8'hD2},  // R3 fill_hi=1
        {1'b1, 2'b10, 1'b0, 1'b1, 8'h00, 8'h69},  // R3 fill_hi=0
        {1'b1, 2'b01, 1'b0, 1'b1, 8'h00, 8'hD3},  // R4 fill_lo=1
        {1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 8'hA6},  // R4 fill_lo=0
        {1'b1, 2'b11, 1'b1, 1'b1, 8'h3C, 8'h3C},  // R2 serial ignored
        {1'b1, 2'b01, 1'b0, 1'b0, 8'h00, 8'h78},  // R6 bit3 -> bit4
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 8'h3C},  // R6 bit4 -> bit3
        {1'b0, 2'b11, 1'b1, 1'b1, 8'hFF, 8'h00},  // R1 clear beats load
        {1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 8'h00},  // R5 hold zero
        {1'b1, 2'b11, 1'b0, 1'b0, 8'h81, 8'h81},  // R2 load edge bits
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 8'h40},  // R3 bit0 lost
        {1'b1, 2'b01, 1'b0, 1'b0, 8'h00, 8'h80}   // R4/R6 back up
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one set of inputs at the falling edge, then sample after the rise.
    task automatic step(input logic c, input logic [1:0] m, input logic h,
                        input logic l, input logic [7:0] d);
        @(negedge clk);
        clear_n = c; mode = m; fill_hi = h; fill_lo = l; data_in = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        logic [7:0] rx;
        // R1: reset state
        step(1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
        step(1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
        check("R1 reset state", data_out, 8'h00);

        for (int i = 0; i < 14; i++) begin
            step(VEC[i][20], VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check($sformatf("vector %0d (R1..R6)", i), data_out, VEC[i][7:0]);
        end

        // R1: clear overrides a shift
        step(1'b1, 2'b11, 1'b0, 1'b0, 8'hFF);
        step(1'b0, 2'b10, 1'b1, 1'b1, 8'h00);
        check("R1 clear beats shift", data_out, 8'h00);

        // R6 parallel-to-serial: load 0x96 and read bit 0 across 8 down-shifts
        step(1'b1, 2'b11, 1'b0, 1'b0, 8'h96);
        rx = 8'h00;
        for (int b = 0; b < 8; b++) begin
            rx[b] = data_out[0];
            step(1'b1, 2'b10, 1'b0, 1'b0, 8'h00);
        end
        check("R6 serial out word", rx, 8'h96);
        check("R3 register drained", data_out, 8'h00);

        // R6 serial-to-parallel: feed 0x5B MSB first into fill_lo
        for (int b = 7; b >= 0; b--) begin
            step(1'b1, 2'b01, 1'b0, b[2:0] inside {3'd6, 3'd4, 3'd3, 3'd1, 3'd0}, 8'h00);
        end
        check("R6 serial in word", data_out, 8'h5B);

        // R5 hold with everything toggling
        step(1'b1, 2'b00, 1'b1, 1'b0, 8'hA0);
        step(1'b1, 2'b00, 1'b0, 1'b1, 8'h0F);
        check("R5 hold", data_out, 8'h5B);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule